// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits next to a small 16-bit-opcode integer core and carries out the entry into synchronous exceptions. When the core presents a request, the block classifies the fetched opcode word together with four event flags from execute: trap instruction, overflow on a trap-on-overflow instruction, bounds failure on a bounds-check instruction, and zero divisor on a divide. It derives an 8-bit vector number, copies the status register, switches the live copy to supervisor mode with tracing off, and writes a three-word frame below the supervisor stack pointer. It then reads the 32-bit handler address from the vector table and presents it as the new program counter.

The core keeps issuing requests as it likes. Requests that carry no cause are dropped. While an entry is in flight, `busy_o` holds the core off and any further request or status-register write is ignored. All memory traffic goes through one 16-bit port. Each access holds its request until an acknowledge arrives.

Top module: `exc_entry_seq`

## Requirements
- R1: Opcode words 0x4AFA, 0x4AFB and 0x4AFC give vector 4, whatever the event flags are.
- R2: An opcode with bits 15..12 equal to 0xA gives vector 10, and one with 0xF gives vector 11. Both outrank the event flags. The three fixed patterns of R1 outrank both.
- R3: If no opcode rule applies and the trap flag is set, the vector is 32 plus opcode bits 3..0 (32..47).
- R4: Otherwise the flags give these vectors: zero divisor 5, bounds failure 6, overflow 7. Priority runs trap, then zero divisor, then bounds, then overflow.
- R5: In the cycle after acceptance, `sr_o` has bit 13 (supervisor) set and bit 15 (trace) clear, and every other bit keeps its old value. The pre-exception value is the one that goes to the stack.
- R6: The frame is written with three word writes at these addresses, in this order: next_pc[15:0] at ssp-2, next_pc[31:16] at ssp-4, and the old status register at ssp-6. `ssp_o` then equals ssp-6.
- R7: After the frame, the block reads the high word at vector*4 and then the low word at vector*4+2. `pc_o` is {high, low}, and `pc_valid_o` pulses for one cycle.
- R8: A memory request keeps its address, write enable and write data unchanged until the cycle in which `mem_ack_i` is high.
- R9: `busy_o` rises in the cycle after acceptance and stays high up to and including the `pc_valid_o` cycle. Requests that arrive while busy are ignored.
- R10: A request with no cause (no opcode rule applies and no flag is set) starts nothing. `busy_o` stays low and `sr_o` is unchanged.
- R11: After reset, `busy_o`, `mem_req_o` and `pc_valid_o` are 0 and `sr_o` is 0x2700.
- R12: `sr_wr_i` loads `sr_wdata_i` only when the block is idle and no request is accepted in the same cycle. When a write and an accepted request coincide, the entry wins and the stacked value is the old status register. A write made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core presents an instruction for exception checking |
| opcode_i | input | 16 | First word of the instruction |
| next_pc_i | input | 32 | Address of the following instruction |
| trap_i | input | 1 | Trap instruction executed |
| trapv_ovf_i | input | 1 | Trap-on-overflow instruction with overflow set |
| chk_oob_i | input | 1 | Bounds check failed |
| div_zero_i | input | 1 | Divide with zero divisor |
| ssp_i | input | 32 | Supervisor stack pointer before entry |
| sr_wr_i | input | 1 | Core write of the status register |
| sr_wdata_i | input | 16 | Status register write value |
| sr_o | output | 16 | Live status register |
| busy_o | output | 1 | Entry in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| pc_valid_o | output | 1 | New PC valid, one-cycle pulse |
| pc_o | output | 32 | Handler address |
| ssp_o | output | 32 | Stack pointer after the frame |
| vector_o | output | 8 | Vector number of the current entry |

## Verification
Two pairs of events can land in the same cycle. The first is a new request and a core status-register write arriving in the cycle of acceptance or during a running entry. The second is an opcode rule firing on the same word where execute also raises one or more flags. The bench provokes the first by raising `sr_wr_i` together with an accepted request, and by pulsing both `req_i` (with an illegal pattern) and `sr_wr_i` while `busy_o` is high. It then checks that the vector, the stacked status word and the live status register match the first entry alone. The second is provoked by sweeping the fixed patterns and line opcodes with every flag set, and flag pairs with each other. The bench judges the vector against the stated priority order under memory latencies of zero to two wait cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned VEC_W = 8;

  localparam logic [VEC_W-1:0] VEC_ILLEGAL   = 8'd4;
  localparam logic [VEC_W-1:0] VEC_DIV_ZERO  = 8'd5;
  localparam logic [VEC_W-1:0] VEC_BOUNDS    = 8'd6;
  localparam logic [VEC_W-1:0] VEC_OVERFLOW  = 8'd7;
  localparam logic [VEC_W-1:0] VEC_LINE_A    = 8'd10;
  localparam logic [VEC_W-1:0] VEC_LINE_F    = 8'd11;
  localparam logic [VEC_W-1:0] VEC_TRAP_BASE = 8'd32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_FETCH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic             trap_i,
  input  logic             trapv_ovf_i,
  input  logic             chk_oob_i,
  input  logic             div_zero_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] vector_o
);
  localparam int NPAT = 3;
  localparam logic [OP_W-1:0] ILL_PAT [NPAT] = '{16'h4AFA, 16'h4AFB, 16'h4AFC};

  logic [NPAT-1:0] pat_hit;
  logic            line_a;
  logic            line_f;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign pat_hit[g] = (opcode_i == ILL_PAT[g]);
  end

  assign line_a = (opcode_i[OP_W-1 -: 4] == 4'hA);
  assign line_f = (opcode_i[OP_W-1 -: 4] == 4'hF);

  // opcode rules outrank execute flags
  always_comb begin
    hit_o    = 1'b1;
    vector_o = '0;
    if (|pat_hit)        vector_o = VEC_ILLEGAL;
    else if (line_a)     vector_o = VEC_LINE_A;
    else if (line_f)     vector_o = VEC_LINE_F;
    else if (trap_i)     vector_o = VEC_TRAP_BASE + {4'd0, opcode_i[3:0]};
    else if (div_zero_i) vector_o = VEC_DIV_ZERO;
    else if (chk_oob_i)  vector_o = VEC_BOUNDS;
    else if (trapv_ovf_i) vector_o = VEC_OVERFLOW;
    else                 hit_o    = 1'b0;
  end
endmodule

// File: rtl/exc_sr_unit.sv
module exc_sr_unit #(
  parameter int unsigned          SR_W     = 16,
  parameter int unsigned          S_BIT    = 13,
  parameter int unsigned          T_BIT    = 15,
  parameter logic [SR_W-1:0]      RESET_SR = 16'h2700
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enter_i,
  input  logic            wr_i,
  input  logic [SR_W-1:0] wdata_i,
  output logic [SR_W-1:0] sr_o,
  output logic [SR_W-1:0] saved_o
);
  localparam logic [SR_W-1:0] KEEP_MASK = ~((SR_W'(1) << S_BIT) | (SR_W'(1) << T_BIT));

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] saved_q;
  logic [SR_W-1:0] sr_entry;

  always_comb begin
    sr_entry        = sr_q;
    sr_entry[S_BIT] = 1'b1;
    sr_entry[T_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= RESET_SR;
      saved_q <= RESET_SR;
    end else if (enter_i) begin
      saved_q <= sr_q;
      sr_q    <= sr_entry;
    end else if (wr_i) begin
      sr_q <= wdata_i;
    end
  end

  assign sr_o    = sr_q;
  assign saved_o = saved_q;

  // R5: supervisor on, trace off, old value kept for the frame
  p_sup_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> sr_o[S_BIT] && !sr_o[T_BIT] && (saved_o == $past(sr_o)));

  // R5: other bits untouched by entry
  p_keep_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (sr_o & KEEP_MASK) == ($past(sr_o) & KEEP_MASK));
endmodule

// File: rtl/exc_mem_seq.sv
module exc_mem_seq
  import exc_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 16,
  parameter int unsigned SR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic [AW-1:0]    ret_pc_i,
  input  logic [AW-1:0]    ssp_i,
  input  logic [SR_W-1:0]  sr_copy_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             pc_valid_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    ssp_o,
  output logic [VEC_W-1:0] vector_o
);
  localparam int unsigned WORDS       = AW / DW;
  localparam int unsigned BYTES       = DW / 8;
  localparam int unsigned FRAME       = WORDS + 1;
  localparam int unsigned FRAME_BYTES = FRAME * BYTES;
  localparam int unsigned VEC_SCALE   = AW / 8;
  localparam int unsigned STEP_W      = $clog2(FRAME + 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [VEC_W-1:0]  vec_q;
  logic [AW-1:0]     ret_q;
  logic [AW-1:0]     ssp_q;
  logic [AW-1:0]     handler_q;
  logic              last_push;
  logic              last_fetch;
  logic [AW-1:0]     push_addr;
  logic [AW-1:0]     fetch_addr;

  assign last_push  = (step_q == STEP_W'(FRAME - 1));
  assign last_fetch = (step_q == STEP_W'(WORDS - 1));
  assign push_addr  = ssp_q - AW'((32'(step_q) + 1) * BYTES);
  assign fetch_addr = AW'(vec_q) * AW'(VEC_SCALE) + AW'(32'(step_q) * BYTES);

  // frame: return PC low word first, status word last (lowest address)
  always_comb begin
    mem_req_o   = (state_q == ST_PUSH) || (state_q == ST_FETCH);
    mem_we_o    = (state_q == ST_PUSH);
    mem_addr_o  = (state_q == ST_PUSH) ? push_addr : fetch_addr;
    mem_wdata_o = '0;
    if (state_q == ST_PUSH) begin
      if (32'(step_q) < WORDS) mem_wdata_o = ret_q[int'(step_q)*DW +: DW];
      else                     mem_wdata_o = DW'(sr_copy_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      vec_q     <= '0;
      ret_q     <= '0;
      ssp_q     <= '0;
      handler_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vec_q   <= vector_i;
            ret_q   <= ret_pc_i;
            ssp_q   <= ssp_i;
            step_q  <= '0;
            state_q <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (mem_ack_i) begin
            if (last_push) begin
              step_q  <= '0;
              state_q <= ST_FETCH;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack_i) begin
            // high word first
            handler_q[(WORDS-1-int'(step_q))*DW +: DW] <= mem_rdata_i;
            if (last_fetch) state_q <= ST_DONE;
            else            step_q  <= step_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign pc_valid_o = (state_q == ST_DONE);
  assign pc_o       = handler_q;
  assign ssp_o      = ssp_q - AW'(FRAME_BYTES);
  assign vector_o   = vec_q;

  // R8: access held until acknowledged
  p_hold_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                               && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R7: word accesses are aligned
  p_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[0] == 1'b0));

  // R7: new PC is a single-cycle pulse that ends the entry
  p_pc_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_valid_o |=> !pc_valid_o && !busy_o);

  // R6: writes never follow reads within one entry
  p_push_then_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |=> !mem_we_o);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned     AW       = 32,
  parameter int unsigned     DW       = 16,
  parameter int unsigned     SR_W     = 16,
  parameter int unsigned     S_BIT    = 13,
  parameter int unsigned     T_BIT    = 15,
  parameter logic [SR_W-1:0] RESET_SR = 16'h2700
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [AW-1:0]    next_pc_i,
  input  logic             trap_i,
  input  logic             trapv_ovf_i,
  input  logic             chk_oob_i,
  input  logic             div_zero_i,
  input  logic [AW-1:0]    ssp_i,
  input  logic             sr_wr_i,
  input  logic [SR_W-1:0]  sr_wdata_i,
  output logic [SR_W-1:0]  sr_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             pc_valid_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    ssp_o,
  output logic [VEC_W-1:0] vector_o
);
  logic             cls_hit;
  logic [VEC_W-1:0] cls_vec;
  logic             accept;
  logic             sr_wr_ok;
  logic [SR_W-1:0]  sr_saved;

  exc_classify u_classify (
    .opcode_i    (opcode_i),
    .trap_i      (trap_i),
    .trapv_ovf_i (trapv_ovf_i),
    .chk_oob_i   (chk_oob_i),
    .div_zero_i  (div_zero_i),
    .hit_o       (cls_hit),
    .vector_o    (cls_vec)
  );

  // one entry at a time; entry outranks a same-cycle SR write
  assign accept   = req_i && cls_hit && !busy_o;
  assign sr_wr_ok = sr_wr_i && !busy_o && !accept;

  exc_sr_unit #(
    .SR_W     (SR_W),
    .S_BIT    (S_BIT),
    .T_BIT    (T_BIT),
    .RESET_SR (RESET_SR)
  ) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (accept),
    .wr_i    (sr_wr_ok),
    .wdata_i (sr_wdata_i),
    .sr_o    (sr_o),
    .saved_o (sr_saved)
  );

  exc_mem_seq #(
    .AW   (AW),
    .DW   (DW),
    .SR_W (SR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .vector_i    (cls_vec),
    .ret_pc_i    (next_pc_i),
    .ssp_i       (ssp_i),
    .sr_copy_i   (sr_saved),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .pc_valid_o  (pc_valid_o),
    .pc_o        (pc_o),
    .ssp_o       (ssp_o),
    .vector_o    (vector_o)
  );

  // R9: accepted request raises busy next cycle
  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && cls_hit && !busy_o |=> busy_o);

  // R9: busy holds until the new PC is out
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !pc_valid_o |=> busy_o);

  // R10: a request without a cause leaves the block idle
  p_no_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !cls_hit && !busy_o && !sr_wr_i |=> !busy_o && $stable(sr_o));

  // R1: fixed illegal patterns map to vector 4
  p_illegal_vec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && (opcode_i inside {16'h4AFA, 16'h4AFB, 16'h4AFC})
    |=> vector_o == 8'd4);

  // R12: writes are dropped while busy
  p_wr_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !pc_valid_o |=> $stable(sr_o));
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] next_pc = '0;
  logic        f_trap = 0, f_ovf = 0, f_chk = 0, f_div = 0;
  logic [31:0] ssp = '0;
  logic        sr_wr = 1'b0;
  logic [15:0] sr_wdata = '0;
  logic [15:0] sr_o;
  logic        busy_o, mem_req_o, mem_we_o, pc_valid_o;
  logic [31:0] mem_addr_o, pc_o, ssp_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  vector_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .opcode_i(opcode), .next_pc_i(next_pc),
    .trap_i(f_trap), .trapv_ovf_i(f_ovf), .chk_oob_i(f_chk), .div_zero_i(f_div),
    .ssp_i(ssp), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .sr_o(sr_o), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .pc_valid_o(pc_valid_o), .pc_o(pc_o), .ssp_o(ssp_o), .vector_o(vector_o)
  );

  logic [15:0] mem [0:4095];
  int lat = 0;
  int wcnt = 0;
  bit pend = 0;
  logic [31:0] p_addr;
  logic [15:0] p_wdata;
  logic        p_we;
  logic [31:0] wlog [0:7];
  logic [31:0] rlog [0:7];
  int wn = 0;
  int rn = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model: ack after lat idle cycles, driven at negedge
  always @(negedge clk) begin
    if (pend) begin
      chk("R8", "held address", mem_addr_o, p_addr);
      chk("R8", "held we/data", {15'd0, mem_we_o, mem_wdata_o}, {15'd0, p_we, p_wdata});
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr_o[12:1]];
        wcnt = 0;
      end else wcnt++;
    end
    pend = mem_req_o && !mem_ack;
    p_addr = mem_addr_o; p_we = mem_we_o; p_wdata = mem_wdata_o;
  end

  always @(posedge clk) begin
    if (mem_req_o && mem_ack) begin
      if (mem_we_o) begin
        mem[mem_addr_o[12:1]] = mem_wdata_o;
        if (wn < 8) wlog[wn] = mem_addr_o;
        wn++;
      end else begin
        if (rn < 8) rlog[rn] = mem_addr_o;
        rn++;
      end
    end
  end

  function automatic logic [31:0] handler(input logic [7:0] v);
    return {16'hA000 + 16'(v), 16'h0100 + 16'(v) * 16'd4};
  endfunction

  // expected vector from R1..R4
  function automatic logic [8:0] exp_vec(input logic [15:0] op, input logic t, input logic o,
                                         input logic c, input logic d);
    if (op == 16'h4AFA || op == 16'h4AFB || op == 16'h4AFC) return {1'b1, 8'd4};
    if (op[15:12] == 4'hA) return {1'b1, 8'd10};
    if (op[15:12] == 4'hF) return {1'b1, 8'd11};
    if (t) return {1'b1, 8'd32 + {4'd0, op[3:0]}};
    if (d) return {1'b1, 8'd5};
    if (c) return {1'b1, 8'd6};
    if (o) return {1'b1, 8'd7};
    return 9'd0;
  endfunction

  task automatic write_sr(input logic [15:0] v);
    @(negedge clk);
    sr_wr = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_wr = 1'b0;
    chk("R12", "idle SR write", {16'd0, sr_o}, {16'd0, v});
  endtask

  // one entry; same_wr: SR write in accept cycle; inject: req+write while busy
  task automatic run_entry(input logic [15:0] op, input logic [3:0] fl, input logic [31:0] pc,
                           input logic [31:0] sp, input bit same_wr, input bit inject);
    logic [8:0]  ev;
    logic [15:0] sr_old, sr_ent;
    int guard;
    ev = exp_vec(op, fl[3], fl[2], fl[1], fl[0]);
    @(negedge clk);
    sr_old = sr_o;
    sr_ent = (sr_old | 16'h2000) & ~16'h8000;
    wn = 0; rn = 0;
    req = 1'b1; opcode = op; next_pc = pc; ssp = sp;
    {f_trap, f_ovf, f_chk, f_div} = fl;
    if (same_wr) begin sr_wr = 1'b1; sr_wdata = ~sr_old; end
    @(negedge clk);
    req = 1'b0; sr_wr = 1'b0; {f_trap, f_ovf, f_chk, f_div} = 4'd0;
    ssp = 32'h0; next_pc = 32'h0; opcode = 16'h4E71;
    chk("R9", "busy after accept", {31'd0, busy_o}, 32'd1);
    chk("R5", "live SR on entry", {16'd0, sr_o}, {16'd0, sr_ent});
    if (inject) begin
      req = 1'b1; opcode = 16'h4AFC; sr_wr = 1'b1; sr_wdata = 16'h0000;
      @(negedge clk);
      req = 1'b0; sr_wr = 1'b0; opcode = 16'h4E71;
    end
    guard = 0;
    while (!pc_valid_o && guard < 200) begin
      chk("R9", "busy during entry", {31'd0, busy_o}, 32'd1);
      @(negedge clk);
      guard++;
    end
    chk("R7", "pc_valid reached", {31'd0, pc_valid_o}, 32'd1);
    chk("R9", "busy in valid cycle", {31'd0, busy_o}, 32'd1);
    if (ev[8] && ev[7:0] >= 8'd32) chk("R3", "trap vector", {24'd0, vector_o}, {24'd0, ev[7:0]});
    else if (ev[7:0] == 8'd4)      chk("R1", "illegal vector", {24'd0, vector_o}, 32'd4);
    else if (ev[7:0] >= 8'd10)     chk("R2", "line vector", {24'd0, vector_o}, {24'd0, ev[7:0]});
    else                           chk("R4", "flag vector", {24'd0, vector_o}, {24'd0, ev[7:0]});
    chk("R7", "handler pc", pc_o, handler(ev[7:0]));
    chk("R6", "final ssp", ssp_o, sp - 32'd6);
    chk("R12", "SR after entry", {16'd0, sr_o}, {16'd0, sr_ent});
    chk("R6", "write count", wn, 3);
    chk("R6", "1st write addr", wlog[0], sp - 32'd2);
    chk("R6", "2nd write addr", wlog[1], sp - 32'd4);
    chk("R6", "3rd write addr", wlog[2], sp - 32'd6);
    chk("R6", "stacked pc lo", {16'd0, mem[(sp - 32'd2) >> 1 & 32'hFFF]}, {16'd0, pc[15:0]});
    chk("R6", "stacked pc hi", {16'd0, mem[(sp - 32'd4) >> 1 & 32'hFFF]}, {16'd0, pc[31:16]});
    chk("R5", "stacked SR", {16'd0, mem[(sp - 32'd6) >> 1 & 32'hFFF]}, {16'd0, sr_old});
    chk("R7", "read count", rn, 2);
    chk("R7", "high word addr", rlog[0], {22'd0, ev[7:0], 2'b00});
    chk("R7", "low word addr", rlog[1], {22'd0, ev[7:0], 2'b10});
    @(negedge clk);
    chk("R7", "pulse one cycle", {31'd0, pc_valid_o}, 32'd0);
    chk("R9", "idle after entry", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic no_cause(input logic [15:0] op);
    logic [15:0] s;
    @(negedge clk);
    s = sr_o;
    req = 1'b1; opcode = op;
    @(negedge clk);
    req = 1'b0;
    chk("R10", "no busy", {31'd0, busy_o}, 32'd0);
    chk("R10", "no mem req", {31'd0, mem_req_o}, 32'd0);
    chk("R10", "SR unchanged", {16'd0, sr_o}, {16'd0, s});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    for (int v = 0; v < 64; v++) begin
      mem[v*2]   = handler(8'(v))[31:16];
      mem[v*2+1] = handler(8'(v))[15:0];
    end
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", {31'd0, busy_o}, 32'd0);
    chk("R11", "reset mem_req", {31'd0, mem_req_o}, 32'd0);
    chk("R11", "reset pc_valid", {31'd0, pc_valid_o}, 32'd0);
    chk("R11", "reset SR", {16'd0, sr_o}, 32'h2700);
    rst_n = 1'b1;
    n = 0;
    for (int l = 0; l < 3; l++) begin
      lat = l;
      // R1 fixed patterns, alone and with every flag
      for (int p = 0; p < 3; p++) begin
        write_sr(16'h8000 | 16'(n * 37));
        run_entry(16'h4AFA + 16'(p), 4'b0000, 32'h0001_2000 + 32'(n*6), 32'h1F00 - 32'(n*8), 0, 0);
        n++;
        run_entry(16'h4AFA + 16'(p), 4'b1111, 32'h0003_4000 + 32'(n*6), 32'h1E00 - 32'(n*8), 0, 0);
        n++;
      end
      // R2 line opcodes with flags
      for (int k = 0; k < 4; k++) begin
        write_sr(16'hA71F ^ 16'(k * 257));
        run_entry(16'hA000 + 16'(k * 16'h0333), 4'(k * 5), 32'hDEAD_0000 + 32'(k*2), 32'h1C00 + 32'(k*16), 0, 0);
        run_entry(16'hF000 + 16'(k * 16'h0333), 4'b1000, 32'h0000_BEEE + 32'(k*2), 32'h1A00 + 32'(k*16), 0, 0);
      end
      // R3 trap vectors 32..47, sometimes with other flags
      for (int v = 0; v < 16; v++) begin
        write_sr(16'h0700 | 16'(v) | (v[0] ? 16'h8000 : 16'h0));
        run_entry(16'h4E40 | 16'(v), {1'b1, 3'(v)}, 32'h0010_0000 + 32'(v*4), 32'h1800 + 32'(v*32), 0, 0);
      end
      // R4 flag vectors and priority
      run_entry(16'h80C1, 4'b0001, 32'h0000_1002, 32'h1900, 0, 0);
      run_entry(16'h4180, 4'b0010, 32'h0000_1004, 32'h1910, 0, 0);
      run_entry(16'h4E76, 4'b0100, 32'h0000_1006, 32'h1920, 0, 0);
      run_entry(16'h4180, 4'b0011, 32'h0000_1008, 32'h1930, 0, 0);
      run_entry(16'h4E76, 4'b0110, 32'h0000_100A, 32'h1940, 0, 0);
      run_entry(16'h4AFD, 4'b0111, 32'h0000_100C, 32'h1950, 0, 0);
      // R10 requests without cause
      no_cause(16'h4E71);
      no_cause(16'h4AFD);
      no_cause(16'h4AF9);
      // R12 SR write with accepted request, R9 request+write while busy
      write_sr(16'h8311);
      run_entry(16'h4AFB, 4'b0000, 32'h0042_0010, 32'h1B00, 1, 0);
      write_sr(16'h0015);
      run_entry(16'h4E4F, 4'b1000, 32'h0042_0020, 32'h1B40, 0, 1);
      run_entry(16'h80C1, 4'b0001, 32'h0042_0030, 32'h1B80, 1, 1);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule